// File: doc/BRIEF.md
# Twelve-Hour BCD Time-of-Day Counter

This block keeps the time of day in twelve-hour form. Its input is a one-cycle tick pulse that comes from the mains frequency, nominally fifty per second. A prescaler counts these ticks and produces a one-second strobe. The strobe drives a chain of three counters: seconds, then minutes, then hours. Seconds and minutes each hold a BCD units digit and a tens digit, and each reads 00 to 59. The hours counter reads 1 to 12 and then returns to 1. It is built from a BCD units digit and a single tens flag.

Everything runs on one system clock. The tick input acts only as an enable. Every wrap is a synchronous load, so an out-of-range digit never appears on the outputs, not even for one cycle. The outputs are the BCD digits and the one-second strobe. Display decoding and time setting are left to the surrounding logic.

Top module: `twelve_hour_clock`

## Requirements
- R1: A synchronous active-high reset sets the displayed time to 12:00:00 and clears the prescaler. After reset, the strobe therefore appears on exactly the TICKS_PER_SEC-th tick.
- R2: `sec_strobe_o` is high only in a cycle where `tick_i` is high. It is high on exactly every TICKS_PER_SEC-th tick, and ticks never advance the count in cycles without `tick_i`.
- R3: Seconds step by one on each strobe. The units digit counts 0 to 9. When the units digit is 9, the tens digit advances (0 to 5) and the units digit returns to 0.
- R4: The seconds stage passes a carry to the minutes stage only on a strobe that finds the seconds at 59. Seconds then go to 00 and minutes step once.
- R5: Minutes follow the same 00 to 59 sequence. They pass a carry to hours only on a carry that finds them at 59.
- R6: The hours run 1, 2, ..., 9, 10, 11, 12, 1. The rollover of the units digit from 9 to 0 sets the tens flag, giving 10. From 12, the next step loads units 1 and clears the flag. This includes 12:59:59 to 01:00:00.
- R7: No illegal value ever appears on the outputs. Tens digits never exceed 5, units digits never exceed 9, hour 0 never appears, and when the hour tens flag is set the hour units digit is at most 2.
- R8: All time digits hold their value in every cycle where `sec_strobe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per mains period |
| sec_strobe_o | output | 1 | High in the cycle the one-second boundary is taken |
| hr_tens_o | output | 1 | Hour tens flag (1 = hours 10 to 12) |
| hr_units_o | output | 4 | Hour units BCD digit |
| min_tens_o | output | 3 | Minute tens digit, 0 to 5 |
| min_units_o | output | 4 | Minute units BCD digit |
| sec_tens_o | output | 3 | Second tens digit, 0 to 5 |
| sec_units_o | output | 4 | Second units BCD digit |

## Verification
The bench walks a complete twelve-hour cycle on a fast-prescaler instance and compares every cycle against a seconds-since-noon model. This catches any of the following faults:
- an hour counter that shows 0 or 13;
- an hour counter that misses the 9-to-10 flag;
- minutes that step on every seconds wrap rather than only at 59;
- a stray 6 in a tens digit.

A second instance uses the default divisor and receives sparse random ticks. On that instance, a prescaler that is off by one, or that counts clock cycles instead of ticks, makes the strobe land on the wrong tick. A final mid-run reset confirms the return to 12:00:00.

// File: rtl/clk12_pkg.sv
package clk12_pkg;

    localparam int UNITS_W = 4;
    localparam int TENS_W  = 3;

    typedef logic [UNITS_W-1:0] bcd_t;
    typedef logic [TENS_W-1:0]  tens_t;

    localparam bcd_t  UNITS_LAST = bcd_t'(9);
    localparam tens_t TENS_LAST  = tens_t'(5);
    localparam bcd_t  HOUR_TOP   = bcd_t'(2);

    typedef struct packed {
        tens_t tens;
        bcd_t  units;
    } sexa_t;

    typedef struct packed {
        logic  tens;
        bcd_t  units;
    } hour_t;

    localparam sexa_t SEXA_ZERO  = '{tens: '0, units: '0};
    localparam hour_t HOUR_RESET = '{tens: 1'b1, units: bcd_t'(2)};

    function automatic logic sexa_at_last(sexa_t v);
        return (v.units == UNITS_LAST) && (v.tens == TENS_LAST);
    endfunction

    function automatic sexa_t sexa_next(sexa_t v);
        sexa_t n;
        n = v;
        if (v.units == UNITS_LAST) begin
            n.units = '0;
            n.tens  = (v.tens == TENS_LAST) ? '0 : tens_t'(v.tens + 1'b1);
        end else begin
            n.units = bcd_t'(v.units + 1'b1);
        end
        return n;
    endfunction

    function automatic hour_t hour_next(hour_t v);
        hour_t n;
        if (v.tens && v.units == HOUR_TOP) begin
            n.tens  = 1'b0;
            n.units = bcd_t'(1);
        end else if (v.units == UNITS_LAST) begin
            n.tens  = 1'b1;
            n.units = '0;
        end else begin
            n.tens  = v.tens;
            n.units = bcd_t'(v.units + 1'b1);
        end
        return n;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int TICKS_PER_SEC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic sec_o
);
    localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;

    assign sec_o = tick_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= (cnt_q == LAST) ? '0 : CW'(cnt_q + 1'b1);
    end

    // R2: the count stays inside the divisor range
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
    // R2: without a tick the prescaler holds
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q));
    // R1: reset clears the prescaler
    a_r1_prescale_clear: assert property (@(posedge clk)
        rst |=> cnt_q == '0);
endmodule

// File: rtl/sexa_counter.sv
module sexa_counter
    import clk12_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    output sexa_t val_o,
    output logic  carry_o
);
    sexa_t val_q;

    assign val_o   = val_q;
    assign carry_o = en_i && sexa_at_last(val_q);

    always_ff @(posedge clk) begin
        if (rst)
            val_q <= SEXA_ZERO;
        else if (en_i)
            val_q <= sexa_next(val_q);
    end

    // R3 / R7: digits stay legal
    a_r3_units_legal: assert property (@(posedge clk) disable iff (rst)
        val_q.units <= UNITS_LAST);
    a_r7_tens_legal: assert property (@(posedge clk) disable iff (rst)
        val_q.tens <= TENS_LAST);
    // R4: a carry leaves the stage at 00
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        carry_o |=> val_q == SEXA_ZERO);
    // R3: the tens digit only moves when the units wrap
    a_r3_tens_step: assert property (@(posedge clk) disable iff (rst)
        (en_i && val_q.units != UNITS_LAST) |=> $stable(val_q.tens));
    // R8: no enable, no change
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(val_q));
endmodule

// File: rtl/hour_counter.sv
module hour_counter
    import clk12_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    output hour_t val_o
);
    hour_t val_q;

    assign val_o = val_q;

    always_ff @(posedge clk) begin
        if (rst)
            val_q <= HOUR_RESET;
        else if (en_i)
            val_q <= hour_next(val_q);
    end

    // R7: hour 0 and hours above 12 never appear
    a_r7_hour_legal: assert property (@(posedge clk) disable iff (rst)
        val_q.tens ? (val_q.units <= HOUR_TOP)
                   : (val_q.units != '0 && val_q.units <= UNITS_LAST));
    // R6: after 12 comes 1
    a_r6_wrap_to_one: assert property (@(posedge clk) disable iff (rst)
        (en_i && val_q.tens && val_q.units == HOUR_TOP)
            |=> (!val_q.tens && val_q.units == bcd_t'(1)));
    // R6: 9 goes to 10
    a_r6_nine_to_ten: assert property (@(posedge clk) disable iff (rst)
        (en_i && !val_q.tens && val_q.units == UNITS_LAST)
            |=> (val_q.tens && val_q.units == '0));
    // R8
    a_r8_hour_hold: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(val_q));
    // R1
    a_r1_hour_reset: assert property (@(posedge clk)
        rst |=> val_q == HOUR_RESET);
endmodule

// File: rtl/twelve_hour_clock.sv
module twelve_hour_clock
    import clk12_pkg::*;
#(
    parameter int TICKS_PER_SEC = 50
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    output logic       sec_strobe_o,
    output logic       hr_tens_o,
    output logic [3:0] hr_units_o,
    output logic [2:0] min_tens_o,
    output logic [3:0] min_units_o,
    output logic [2:0] sec_tens_o,
    output logic [3:0] sec_units_o
);
    localparam int NSTAGE = 2;   // stage 0 = seconds, stage 1 = minutes

    logic              sec_en;
    logic [NSTAGE:0]   chain_en;
    logic [NSTAGE-1:0] carry;
    sexa_t             stage_val [NSTAGE];
    hour_t             hour_val;

    tick_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_prescale (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .sec_o  (sec_en)
    );

    assign chain_en = {carry, sec_en};

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        sexa_counter u_stage (
            .clk     (clk),
            .rst     (rst),
            .en_i    (chain_en[g]),
            .val_o   (stage_val[g]),
            .carry_o (carry[g])
        );
    end

    hour_counter u_hours (
        .clk   (clk),
        .rst   (rst),
        .en_i  (chain_en[NSTAGE]),
        .val_o (hour_val)
    );

    assign sec_strobe_o = sec_en;
    assign sec_units_o  = stage_val[0].units;
    assign sec_tens_o   = stage_val[0].tens;
    assign min_units_o  = stage_val[1].units;
    assign min_tens_o   = stage_val[1].tens;
    assign hr_units_o   = hour_val.units;
    assign hr_tens_o    = hour_val.tens;

    // R2: the strobe only coincides with a tick
    a_r2_strobe_needs_tick: assert property (@(posedge clk) disable iff (rst)
        sec_strobe_o |-> tick_i);
    // R5: the hours only move when minutes and seconds read 59:59 on a strobe
    a_r5_hour_carry: assert property (@(posedge clk) disable iff (rst)
        !(sec_strobe_o && min_tens_o == 3'd5 && min_units_o == 4'd9
          && sec_tens_o == 3'd5 && sec_units_o == 4'd9)
            |=> $stable({hr_tens_o, hr_units_o}));
endmodule

// File: tb/test_twelve_hour_clock.sv
module test_twelve_hour_clock;

    localparam int DIV_D = 50;
    localparam int DIV_F = 2;
    localparam int HALF_DAY = 43200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_d = 1'b0;
    logic tick_f = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    logic       stb_d, ht_d, stb_f, ht_f;
    logic [3:0] hu_d, mu_d, su_d, hu_f, mu_f, su_f;
    logic [2:0] mt_d, st_d, mt_f, st_f;

    twelve_hour_clock #(.TICKS_PER_SEC(DIV_D)) i_twelve_hour_clock (
        .clk(clk), .rst(rst), .tick_i(tick_d), .sec_strobe_o(stb_d),
        .hr_tens_o(ht_d), .hr_units_o(hu_d), .min_tens_o(mt_d),
        .min_units_o(mu_d), .sec_tens_o(st_d), .sec_units_o(su_d));

    twelve_hour_clock #(.TICKS_PER_SEC(DIV_F)) i_twelve_hour_clock_fast (
        .clk(clk), .rst(rst), .tick_i(tick_f), .sec_strobe_o(stb_f),
        .hr_tens_o(ht_f), .hr_units_o(hu_f), .min_tens_o(mt_f),
        .min_units_o(mu_f), .sec_tens_o(st_f), .sec_units_o(su_f));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int pc_d = 0, secs_d = 0, pc_f = 0, secs_f = 0;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // time as seconds since 12:00:00 -> packed digits {ht,hu,mt,mu,st,su}
    function automatic int exp_code(int s);
        int h, disp, m, sc;
        h = s / 3600;
        disp = (h == 0) ? 12 : h;
        m = (s / 60) % 60;
        sc = s % 60;
        return ((disp / 10) << 20) | ((disp % 10) << 16) | ((m / 10) << 12)
             | ((m % 10) << 8) | ((sc / 10) << 4) | (sc % 10);
    endfunction

    task automatic cmp_time(string who, int s, logic ht, logic [3:0] hu,
                            logic [2:0] mt, logic [3:0] mu,
                            logic [2:0] st, logic [3:0] su);
        int e;
        e = exp_code(s);
        check({st, su} == 7'(e & 8'h7f), {who, " R3 seconds"}, int'({st, su}), e & 8'h7f);
        check({mt, mu} == 7'((e >> 8) & 8'h7f), {who, " R4/R5 minutes"},
              int'({mt, mu}), (e >> 8) & 8'h7f);
        check({ht, hu} == 5'((e >> 16) & 8'h1f), {who, " R6 hours"},
              int'({ht, hu}), (e >> 16) & 8'h1f);
        // R7: legality seen at the ports
        check(st <= 5 && mt <= 5 && su <= 9 && mu <= 9 &&
              (ht ? hu <= 2 : (hu != 0 && hu <= 9)), {who, " R7 legal"}, 0, 0);
    endtask

    initial begin
        int unsigned seed;
        int prev_d, cur_d;
        bit prev_tick_d;
        seed = $urandom(32'h5eed_c10c);
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cmp_time("dflt R1", 0, ht_d, hu_d, mt_d, mu_d, st_d, su_d);
        cmp_time("fast R1", 0, ht_f, hu_f, mt_f, mu_f, st_f, su_f);
        check(stb_d == 1'b0, "R1 strobe idle", int'(stb_d), 0);

        prev_tick_d = 1'b0;
        prev_d = exp_code(0);
        while (secs_f != 1 || pc_f != 0 || checks < 100) begin
            // outputs after the last edge
            cmp_time("fast", secs_f, ht_f, hu_f, mt_f, mu_f, st_f, su_f);
            cmp_time("dflt", secs_d, ht_d, hu_d, mt_d, mu_d, st_d, su_d);
            cur_d = int'({ht_d, hu_d, 1'b0, mt_d, mu_d, 1'b0, st_d, su_d});
            // R8: no tick on the last edge -> nothing moved
            if (!prev_tick_d)
                check(cur_d == prev_d, "R8 hold without tick", cur_d, prev_d);
            prev_d = cur_d;
            // new stimulus
            tick_d = ($urandom % 3) == 0;
            tick_f = ($urandom % 8) != 0;
            #1;
            // R2: strobe on exactly the DIV-th tick
            check(stb_d == (tick_d && pc_d == DIV_D - 1), "R2 strobe dflt",
                  int'(stb_d), int'(tick_d && pc_d == DIV_D - 1));
            check(stb_f == (tick_f && pc_f == DIV_F - 1), "R2 strobe fast",
                  int'(stb_f), int'(tick_f && pc_f == DIV_F - 1));
            if (tick_d) begin
                if (pc_d == DIV_D - 1) begin pc_d = 0; secs_d = (secs_d + 1) % HALF_DAY; end
                else pc_d++;
            end
            if (tick_f) begin
                if (pc_f == DIV_F - 1) begin pc_f = 0; secs_f = (secs_f + 1) % HALF_DAY; end
                else pc_f++;
            end
            prev_tick_d = tick_d;
            @(negedge clk);
        end
        // full half-day passed, wrapped back to 12:00:01
        cmp_time("fast wrap R6", secs_f, ht_f, hu_f, mt_f, mu_f, st_f, su_f);

        // R1: mid-run reset returns to 12:00:00
        tick_d = 1'b1; tick_f = 1'b1; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; tick_d = 1'b0; tick_f = 1'b0;
        cmp_time("dflt R1 again", 0, ht_d, hu_d, mt_d, mu_d, st_d, su_d);
        cmp_time("fast R1 again", 0, ht_f, hu_f, mt_f, mu_f, st_f, su_f);
        // R1: prescaler cleared -> strobe on the 50th tick exactly
        for (int i = 1; i <= DIV_D; i++) begin
            tick_d = 1'b1;
            #1;
            check(stb_d == (i == DIV_D), "R1 prescaler cleared", int'(stb_d), int'(i == DIV_D));
            @(negedge clk);
        end
        tick_d = 1'b0;
        cmp_time("dflt R1 first second", 1, ht_d, hu_d, mt_d, mu_d, st_d, su_d);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule